// File: doc/BRIEF.md
# dq-Frame Current Regulator with Reference Feedforward

This block turns a pair of rotating-frame current errors into a pair of modulation voltage commands for a single-phase grid-tied inverter. At each sample strobe it builds the direct-axis current target by subtracting the load's direct-axis current from the current that the solar array can deliver. It pins the quadrature-axis target to zero, so the converter supplies all of the load's reactive and distortion current. Each axis then runs a discrete proportional-integral regulator and adds feedforward terms derived from the targets. The two feedforward terms carry opposite signs on the two axes.

The array-side current is an input; the outer voltage loop that produces it lies outside this block. All four gains and the integrator limit are inputs that the surrounding logic holds. Currents and outputs use signed Q1.15. Gains use unsigned Q8.8, so the nominal current-loop gains of 8 (proportional) and 2 (integral, sample period folded in) are 0x0800 and 0x0200. Each integrator is bounded by a programmable limit and freezes while its axis output is pinned in the direction it would push. A synchronous clear empties both integrators.

Top module: `dq_current_reg`

## Requirements
- R1: The direct-axis target is `id_pv - id_load`, computed without wrap. The quadrature-axis target is always zero. Each axis error is its target minus its measured current (`id_meas` for the direct axis, `iq_meas` for the quadrature axis).
- R2: `out_vld` is high exactly in the cycle after a clock edge that sampled `sample_stb` high. `vd` and `vq` change only on such edges and otherwise hold their values.
- R3: The proportional term of an axis is `(err * kp) >>> 8`, where `kp` is unsigned Q8.8 and the shift rounds toward minus infinity.
- R4: On each strobe, the integrator of an axis advances by `(err * ki) >>> 8`. The output computed at that strobe uses the integrator value from before the advance.
- R5: After every strobe without a clear, each integrator lies in `[-integ_lim, +integ_lim]`, with `integ_lim` read as an unsigned count of Q1.15 LSBs.
- R6: If the unsaturated sum of an axis is above 32767 and its integral increment is positive, or below -32768 and its increment is negative, that integrator keeps its value at that strobe.
- R7: Each output is the sum of its proportional term, its integrator and its feedforward, saturated to the range -32768..32767 (plus and minus one in Q1.15).
- R8: The direct-axis feedforward is `(id_tgt*kd)>>>8 - (iq_tgt*kq)>>>8`. The quadrature-axis feedforward is `(id_tgt*kd)>>>8 + (iq_tgt*kq)>>>8`. Both gains are unsigned Q8.8.
- R9: `integ_clr` sets both integrators to zero at the next edge. If a strobe arrives in the same cycle, its outputs use the integrator values from before the clear.
- R10: While `rst` is high, both outputs, both integrators and `out_vld` go to zero at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb | input | 1 | One-cycle sample strobe that triggers an update |
| integ_clr | input | 1 | Synchronous clear of both integrators |
| id_pv | input | 16 | Array-side direct-axis current, signed Q1.15 |
| id_load | input | 16 | Load direct-axis current, signed Q1.15 |
| id_meas | input | 16 | Measured direct-axis current, signed Q1.15 |
| iq_meas | input | 16 | Measured quadrature-axis current, signed Q1.15 |
| kp | input | 16 | Proportional gain, unsigned Q8.8 |
| ki | input | 16 | Integral gain per sample, unsigned Q8.8 |
| kd | input | 16 | Direct-target feedforward gain, unsigned Q8.8 |
| kq | input | 16 | Quadrature-target feedforward gain, unsigned Q8.8 |
| integ_lim | input | 16 | Integrator magnitude bound, unsigned Q1.15 LSBs |
| vd | output | 16 | Direct-axis voltage command, signed Q1.15 |
| vq | output | 16 | Quadrature-axis voltage command, signed Q1.15 |
| out_vld | output | 1 | Outputs updated in this cycle |

## Verification
The integrator checks assume that `integ_lim` stays within 0..32767 and does not shrink below an integrator's present magnitude except together with a clear. The windup check also applies only while the integrator already lies inside the current bound. The stimulus changes the limit only in a cycle that also asserts `integ_clr`, and it keeps every limit at or below 20000. Gains, currents and the limit are otherwise free to change between strobes. The stimulus exercises idle cycles, back-to-back strobes, clears with and without a strobe, and long saturated stretches in both directions.

// File: rtl/dqreg_pkg.sv
package dqreg_pkg;

    // Fixed-point format shared by every stage
    localparam int DATA_W    = 16;   // Q1.15 currents and commands
    localparam int GAIN_W    = 16;   // unsigned gains
    localparam int GAIN_FRAC = 8;    // Q8.8
    localparam int WIDE_W    = 48;   // internal headroom
    localparam int NUM_AX    = 2;

    localparam logic [GAIN_W-1:0] KP_NOMINAL = 16'h0800;  // 8.0
    localparam logic [GAIN_W-1:0] KI_NOMINAL = 16'h0200;  // 2.0

    typedef enum int {
        AX_D = 0,
        AX_Q = 1
    } axis_e;

    typedef logic signed [WIDE_W-1:0] wide_t;

    typedef struct packed {
        wide_t d;
        wide_t q;
    } wide_pair_t;

    // Scale a wide value by an unsigned Q8.8 gain, flooring the fraction
    function automatic wide_t gain_mul(input wide_t x, input logic [GAIN_W-1:0] g);
        wide_t gx;
        gx = wide_t'({{(WIDE_W-GAIN_W){1'b0}}, g});
        return (x * gx) >>> GAIN_FRAC;
    endfunction

    function automatic wide_t clamp(input wide_t x, input wide_t lo, input wide_t hi);
        if (x > hi) return hi;
        if (x < lo) return lo;
        return x;
    endfunction

endpackage

// File: rtl/dqreg_ref.sv
module dqreg_ref
    import dqreg_pkg::*;
(
    input  logic signed [DATA_W-1:0] id_pv,
    input  logic signed [DATA_W-1:0] id_load,
    input  logic        [GAIN_W-1:0] kd,
    input  logic        [GAIN_W-1:0] kq,
    output wide_pair_t               tgt_o,
    output wide_pair_t               ff_o
);

    localparam wide_t IQ_TGT = '0;

    wide_t id_tgt;
    wide_t d_term;
    wide_t q_term;

    always_comb begin
        id_tgt  = wide_t'(id_pv) - wide_t'(id_load);
        d_term  = gain_mul(id_tgt, kd);
        q_term  = gain_mul(IQ_TGT, kq);
        tgt_o.d = id_tgt;
        tgt_o.q = IQ_TGT;
        ff_o.d  = d_term - q_term;
        ff_o.q  = d_term + q_term;
    end

endmodule

// File: rtl/dqreg_axis.sv
module dqreg_axis
    import dqreg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     stb,
    input  logic                     clr,
    input  wide_t                    tgt_i,
    input  logic signed [DATA_W-1:0] meas_i,
    input  wide_t                    ff_i,
    input  logic        [GAIN_W-1:0] kp,
    input  logic        [GAIN_W-1:0] ki,
    input  logic        [DATA_W-1:0] lim,
    output logic signed [DATA_W-1:0] out_o
);

    localparam wide_t OUT_MAX = wide_t'((64'sd1 <<< (DATA_W-1)) - 64'sd1);
    localparam wide_t OUT_MIN = -wide_t'(64'sd1 <<< (DATA_W-1));

    wide_t acc;
    wide_t acc_n;
    wide_t err;
    wide_t p_term;
    wide_t i_inc;
    wide_t sum;
    wide_t out_n;
    wide_t lim_w;
    logic  sat_hi;
    logic  sat_lo;
    logic  wind;

    always_comb begin
        err    = tgt_i - wide_t'(meas_i);
        p_term = gain_mul(err, kp);
        i_inc  = gain_mul(err, ki);
        sum    = p_term + acc + ff_i;
        sat_hi = (sum > OUT_MAX);
        sat_lo = (sum < OUT_MIN);
        out_n  = sat_hi ? OUT_MAX : (sat_lo ? OUT_MIN : sum);
        wind   = (sat_hi && (i_inc > 0)) || (sat_lo && (i_inc < 0));
        lim_w  = wide_t'({{(WIDE_W-DATA_W){1'b0}}, lim});
        acc_n  = clamp(wind ? acc : (acc + i_inc), -lim_w, lim_w);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            out_o <= '0;
        end else begin
            if (stb) out_o <= out_n[DATA_W-1:0];
            if (clr)      acc <= '0;
            else if (stb) acc <= acc_n;
        end
    end

    // R5
    acc_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && !clr) |=> ((acc <= $past(lim_w)) && (acc >= -$past(lim_w))));

    // R9
    acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc == '0));

    // R6
    windup_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && !clr && wind && (acc <= lim_w) && (acc >= -lim_w)) |=> (acc == $past(acc)));

    // R4
    no_stb_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (!stb && !clr) |=> $stable(acc));

endmodule

// File: rtl/dq_current_reg.sv
module dq_current_reg
    import dqreg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sample_stb,
    input  logic                     integ_clr,
    input  logic signed [DATA_W-1:0] id_pv,
    input  logic signed [DATA_W-1:0] id_load,
    input  logic signed [DATA_W-1:0] id_meas,
    input  logic signed [DATA_W-1:0] iq_meas,
    input  logic        [GAIN_W-1:0] kp,
    input  logic        [GAIN_W-1:0] ki,
    input  logic        [GAIN_W-1:0] kd,
    input  logic        [GAIN_W-1:0] kq,
    input  logic        [DATA_W-1:0] integ_lim,
    output logic signed [DATA_W-1:0] vd,
    output logic signed [DATA_W-1:0] vq,
    output logic                     out_vld
);

    wide_pair_t              tgt_pair;
    wide_pair_t              ff_pair;
    wide_t                   tgt_arr  [NUM_AX];
    wide_t                   ff_arr   [NUM_AX];
    logic signed [DATA_W-1:0] meas_arr [NUM_AX];
    logic signed [DATA_W-1:0] out_arr  [NUM_AX];

    dqreg_ref u_ref (
        .id_pv   (id_pv),
        .id_load (id_load),
        .kd      (kd),
        .kq      (kq),
        .tgt_o   (tgt_pair),
        .ff_o    (ff_pair)
    );

    always_comb begin
        tgt_arr[AX_D]  = wide_t'(tgt_pair.d);
        tgt_arr[AX_Q]  = wide_t'(tgt_pair.q);
        ff_arr[AX_D]   = wide_t'(ff_pair.d);
        ff_arr[AX_Q]   = wide_t'(ff_pair.q);
        meas_arr[AX_D] = id_meas;
        meas_arr[AX_Q] = iq_meas;
    end

    for (genvar g = 0; g < NUM_AX; g++) begin : g_axis
        dqreg_axis u_axis (
            .clk    (clk),
            .rst    (rst),
            .stb    (sample_stb),
            .clr    (integ_clr),
            .tgt_i  (tgt_arr[g]),
            .meas_i (meas_arr[g]),
            .ff_i   (ff_arr[g]),
            .kp     (kp),
            .ki     (ki),
            .lim    (integ_lim),
            .out_o  (out_arr[g])
        );
    end

    assign vd = out_arr[AX_D];
    assign vq = out_arr[AX_Q];

    always_ff @(posedge clk) begin
        if (rst) out_vld <= 1'b0;
        else     out_vld <= sample_stb;
    end

    // R2
    vld_after_stb_chk: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> out_vld);

    // R2
    vld_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_stb |=> !out_vld);

    // R2
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_stb |=> ($stable(vd) && $stable(vq)));

endmodule

// File: tb/test_dq_current_reg.sv
`timescale 1ns/1ps
module test_dq_current_reg;
    import dqreg_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_stb = 1'b0;
    logic integ_clr = 1'b0;
    logic signed [15:0] id_pv = '0, id_load = '0, id_meas = '0, iq_meas = '0;
    logic [15:0] kp = '0, ki = '0, kd = '0, kq = '0, integ_lim = '0;
    logic signed [15:0] vd, vq;
    logic out_vld;

    int checks = 0;
    int fails = 0;
    string cur_req = "R10";
    bit done = 1'b0;

    always #2 clk = ~clk;

    dq_current_reg i_dq_current_reg (
        .clk(clk), .rst(rst), .sample_stb(sample_stb), .integ_clr(integ_clr),
        .id_pv(id_pv), .id_load(id_load), .id_meas(id_meas), .iq_meas(iq_meas),
        .kp(kp), .ki(ki), .kd(kd), .kq(kq), .integ_lim(integ_lim),
        .vd(vd), .vq(vq), .out_vld(out_vld)
    );

    // Behavioural reference model
    longint m_acc [2];
    longint m_vd = 0, m_vq = 0;
    bit     m_vld = 1'b0;

    function automatic longint gmul(input longint x, input longint g);
        return (x * g) >>> 8;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_acc[0] = 0; m_acc[1] = 0; m_vd = 0; m_vq = 0; m_vld = 1'b0;
        end else begin
            m_vld = sample_stb;
            if (sample_stb) begin
                longint tg [2];
                longint ms [2];
                longint ff [2];
                longint e, p, inc, s, o, nxt, lim_l;
                tg[0] = longint'(id_pv) - longint'(id_load);
                tg[1] = 0;
                ff[0] = gmul(tg[0], longint'(kd)) - gmul(tg[1], longint'(kq));
                ff[1] = gmul(tg[0], longint'(kd)) + gmul(tg[1], longint'(kq));
                ms[0] = longint'(id_meas);
                ms[1] = longint'(iq_meas);
                lim_l = longint'(integ_lim);
                for (int a = 0; a < 2; a++) begin
                    e   = tg[a] - ms[a];
                    p   = gmul(e, longint'(kp));
                    inc = gmul(e, longint'(ki));
                    s   = p + m_acc[a] + ff[a];
                    o   = (s > 32767) ? 32767 : ((s < -32768) ? -32768 : s);
                    nxt = ((s > 32767 && inc > 0) || (s < -32768 && inc < 0)) ? m_acc[a] : m_acc[a] + inc;
                    if (nxt > lim_l)  nxt = lim_l;
                    if (nxt < -lim_l) nxt = -lim_l;
                    m_acc[a] = nxt;
                    if (a == 0) m_vd = o; else m_vq = o;
                end
            end
            if (integ_clr) begin
                m_acc[0] = 0; m_acc[1] = 0;
            end
        end
    end

    // Compare every cycle away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (longint'(vd) != m_vd || longint'(vq) != m_vq || out_vld != m_vld) begin
                fails++;
                $display("FAIL %s t=%0t vd=%0d vq=%0d vld=%0d expected vd=%0d vq=%0d vld=%0d",
                         cur_req, $time, vd, vq, out_vld, m_vd, m_vq, m_vld);
            end
        end
    end

    task automatic check_val(input string req, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic drive(input bit s, input bit c, input int pv, input int ld, input int dm, input int qm);
        @(negedge clk);
        sample_stb = s;
        integ_clr  = c;
        id_pv      = 16'(pv);
        id_load    = 16'(ld);
        id_meas    = 16'(dm);
        iq_meas    = 16'(qm);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, i * 37, -i * 11, i * 5, -i * 3);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL R2 watchdog expired");
        finish_run();
    end

    initial begin
        // R10: reset state, with a strobe held during reset
        sample_stb = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0; sample_stb = 1'b0;
        check_val("R10 vd", vd, 0);
        check_val("R10 vq", vq, 0);
        check_val("R10 vld", out_vld, 0);

        // R3 and R1: proportional only at nominal gain
        cur_req = "R3";
        kp = KP_NOMINAL; ki = '0; kd = '0; kq = '0; integ_lim = 16'd16000;
        drive(1, 0, 1000, 200, 500, -300);
        drive(0, 0, 0, 0, 0, 0);
        check_val("R3 vd", vd, 2400);
        check_val("R1 vq", vq, 2400);
        drive(1, 0, -500, 100, 0, 77);
        drive(0, 0, 0, 0, 0, 0);
        check_val("R3 vd neg", vd, -4800);
        check_val("R1 vq", vq, -616);
        drive(1, 0, 3, 0, 0, 0);   // odd fraction rounding
        kp = 16'h0081;
        drive(1, 0, -3, 0, 0, 0);

        // R2: quiet cycles keep outputs
        cur_req = "R2";
        idle(6);
        check_val("R2 hold vd", vd, -2);

        // R4: integral accumulation, back-to-back strobes
        cur_req = "R4";
        kp = '0; ki = KI_NOMINAL;
        for (int i = 0; i < 4; i++) drive(1, 0, 100, 0, 0, -50);
        drive(0, 0, 0, 0, 0, 0);
        check_val("R4 vd uses prior integrator", vd, 600);
        drive(1, 0, 0, 100, -7, 9);
        idle(2);

        // R5: clamp at a small limit (limit changes only with a clear)
        cur_req = "R5";
        drive(0, 1, 0, 0, 0, 0);
        integ_lim = 16'd500;
        for (int i = 0; i < 3; i++) drive(1, 0, 1000, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0);
        check_val("R5 vd at limit", vd, 500);
        for (int i = 0; i < 3; i++) drive(1, 0, -1000, 0, 0, 1000);
        drive(0, 0, 0, 0, 0, 0);
        check_val("R5 vd at lower limit", vd, -500);

        // R6 and R7: saturation with windup hold
        cur_req = "R6";
        drive(0, 1, 0, 0, 0, 0);
        integ_lim = 16'd20000;
        kp = 16'h7FFF; ki = KI_NOMINAL;
        for (int i = 0; i < 4; i++) drive(1, 0, 10000, 0, 0, -10000);
        drive(0, 0, 0, 0, 0, 0);
        check_val("R7 vd high", vd, 32767);
        check_val("R7 vq high", vq, 32767);
        for (int i = 0; i < 4; i++) drive(1, 0, -10000, 0, 0, 10000);
        drive(0, 0, 0, 0, 0, 0);
        check_val("R7 vd low", vd, -32768);
        kp = '0;
        drive(1, 0, 10, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0);
        check_val("R6 integrator held at zero", vd, 0);
        kp = 16'h0400;
        for (int i = 0; i < 20; i++) drive(1, 0, 6000, 0, -2000, 3000);

        // R8: feedforward terms
        cur_req = "R8";
        drive(0, 1, 0, 0, 0, 0);
        kp = KP_NOMINAL; ki = '0; kd = 16'h0180; kq = 16'h0300;
        drive(1, 0, 2000, 600, 1400, 0);
        drive(0, 0, 0, 0, 0, 0);
        check_val("R8 vd ff", vd, 2100);
        check_val("R8 vq ff", vq, 2100);
        drive(1, 0, -4000, 3000, 0, 500);
        drive(1, 0, 30000, -30000, 0, 0);
        drive(0, 0, 0, 0, 0, 0);

        // R9: clear alone and together with a strobe
        cur_req = "R9";
        kp = '0; kd = '0; kq = '0; ki = 16'h0100;
        for (int i = 0; i < 3; i++) drive(1, 0, 700, 0, 0, -700);
        drive(1, 1, 700, 0, 0, -700);
        drive(0, 0, 0, 0, 0, 0);
        check_val("R9 stb with clear uses old", vd, 2100);
        drive(1, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0);
        check_val("R9 integrator cleared", vd, 0);
        drive(0, 1, 0, 0, 0, 0);
        idle(2);

        // R1: mixed traffic across all paths
        cur_req = "R1";
        kp = KP_NOMINAL; ki = KI_NOMINAL; kd = 16'h0040; kq = 16'h0200;
        for (int i = 0; i < 3000; i++) begin
            drive(($urandom_range(0, 2) != 0), ($urandom_range(0, 60) == 0),
                  int'($urandom_range(0, 16000)) - 8000, int'($urandom_range(0, 8000)) - 4000,
                  int'($urandom_range(0, 16000)) - 8000, int'($urandom_range(0, 8000)) - 4000);
            if (i == 1500) begin
                kp = 16'h1000; kd = 16'h0100;
            end
        end
        idle(3);
        finish_run();
    end

endmodule